// File: doc/BRIEF.md
# Interrupt Flag Bank with Watch Timer

This block gathers the interrupt requests of a small 8-bit processor. Three maskable sources land in a flag register: a watch timer derived from the 32.768 kHz time base, a pulse from a general-purpose timer, and a falling edge on any port pin whose wake enable is set. A fourth, non-maskable source is a one-cycle pulse at 64 Hz. The watch timer and the 64 Hz pulse come from one shared binary divider. The divider advances on a 32.768 kHz clock-enable strobe that arrives in the system clock domain.

Software reads the flag register and clears flags by writing zeros. A one written to a flag position leaves that flag as it is. A handler can therefore read the flags, invert the value and write it back, and this clears exactly the flags it saw. A flag that rises between the read and the write is kept. The interrupt request line stays high while any flag is set, so an uncleared flag makes the processor take the interrupt again. A one-bit rate control selects a watch interval of half a second or one second.

Top module: `irq_watch_ctrl`

## Requirements
- R1: After reset all flags read 0, `irq` and `nmi` are low, and the watch rate is the half-second setting (rate bit 0).
- R2: A flag write with a 0 in bit position n (0 watch, 1 timer, 2 external) clears flag n on the next clock edge. A 1 in position n leaves flag n unchanged.
- R3: If a set event for flag n occurs in the same cycle as a write that clears flag n, the flag is 1 after that edge.
- R4: `irq` is high exactly when at least one of `flag_rd[2:0]` is 1. Bits `flag_rd[7:3]` always read 0.
- R5: `nmi` is a single-cycle pulse in the cycle after every 2^NMI_SHIFT-th `tick_32k` strobe.
- R6: With rate bit 0, flag 0 sets after every 2^(DIV_W-1)-th strobe. With rate bit 1 it sets after every 2^DIV_W-th strobe. Strobes are counted from reset by the shared divider.
- R7: A one-cycle `timer_pulse` sets flag 1 on the next edge.
- R8: A falling edge on `port_pins[k]` while `wake_en[k]` is 1 sets flag 2 on the third clock edge after the pin change, because the pin passes through two synchronizer stages. Rising edges, and edges on pins whose enable is 0, have no effect.
- R9: Without an event or a clearing write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at 32.768 kHz |
| timer_pulse | input | 1 | Overflow pulse from the general timer |
| port_pins | input | PORT_W | Asynchronous port pin levels |
| wake_en | input | PORT_W | Per-pin falling-edge interrupt enable |
| rate_we | input | 1 | Write strobe for the rate control bit |
| rate_wdata | input | 1 | Rate value: 0 for half second, 1 for one second |
| flag_we | input | 1 | Write strobe for the flag register |
| flag_wdata | input | 3 | Write-zero-to-clear data, bit n maps to flag n |
| flag_rd | output | 8 | Flag register read value |
| irq | output | 1 | Maskable interrupt request |
| nmi | output | 1 | Non-maskable interrupt pulse |

## Verification
The properties assume that `timer_pulse` and `flag_we` come from logic in the same clock domain and hold steady across each edge. They also assume that the port pins, once synchronized, are sampled only through the edge detector. The bench drives all inputs on the falling clock edge and issues one-cycle strobes only. Between pin transitions it leaves at least four cycles, so that each transition has passed through both synchronizer stages before the next one arrives. The divider is shrunk to six bits so that many full watch periods fit into a short run, at both rate settings.

// File: rtl/irqwt_pkg.sv
package irqwt_pkg;
  localparam int FLAG_W   = 3;
  localparam int IDX_WTCH = 0;
  localparam int IDX_TMR  = 1;
  localparam int IDX_EXT  = 2;
  typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/wt_divider.sv
module wt_divider #(
  parameter int DIV_W     = 15,
  parameter int NMI_SHIFT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic rate_1s,
  output logic nmi_q,
  output logic watch_evt
);
  localparam int HALF_W = DIV_W - 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             nmi_d;
  logic             half_hit, full_hit;

  always_comb begin
    half_hit  = &cnt_q[HALF_W-1:0];
    full_hit  = &cnt_q;
    cnt_d     = tick_en ? cnt_q + 1'b1 : cnt_q;
    nmi_d     = tick_en & (&cnt_q[NMI_SHIFT-1:0]);
    watch_evt = tick_en & (rate_1s ? full_hit : half_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      nmi_q <= nmi_d;
    end
  end
endmodule

// File: rtl/pin_fall_detect.sv
module pin_fall_detect #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] enable,
  output logic              fall_any
);
  logic [PORT_W-1:0] s1_q, s2_q, prev_q;
  logic [PORT_W-1:0] fall_vec;

  always_comb begin
    for (int k = 0; k < PORT_W; k++) begin
      fall_vec[k] = prev_q[k] & ~s2_q[k] & enable[k];
    end
    fall_any = |fall_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pins;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import irqwt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set_vec,
  input  logic   wr_en,
  input  flags_t wr_data,
  output flags_t flags
);
  flags_t flg_q, flg_d, keep_mask;

  always_comb begin
    keep_mask = wr_en ? wr_data : '1;
    for (int n = 0; n < FLAG_W; n++) begin
      flg_d[n] = set_vec[n] | (flg_q[n] & keep_mask[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/irq_watch_ctrl.sv
module irq_watch_ctrl
  import irqwt_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int NMI_SHIFT = 9,
  parameter int PORT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              timer_pulse,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [PORT_W-1:0] wake_en,
  input  logic              rate_we,
  input  logic              rate_wdata,
  input  logic              flag_we,
  input  logic [2:0]        flag_wdata,
  output logic [7:0]        flag_rd,
  output logic              irq,
  output logic              nmi
);
  localparam int RD_W  = 8;
  localparam int PAD_W = RD_W - FLAG_W;

  logic   rate_q, rate_d;
  logic   watch_evt, ext_evt;
  flags_t set_vec, flags;

  always_comb rate_d = rate_we ? rate_wdata : rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= 1'b0;
    else        rate_q <= rate_d;
  end

  wt_divider #(.DIV_W(DIV_W), .NMI_SHIFT(NMI_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_32k), .rate_1s(rate_q),
    .nmi_q(nmi), .watch_evt(watch_evt)
  );

  pin_fall_detect #(.PORT_W(PORT_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins(port_pins), .enable(wake_en),
    .fall_any(ext_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_WTCH] = watch_evt;
    set_vec[IDX_TMR]  = timer_pulse;
    set_vec[IDX_EXT]  = ext_evt;
  end

  flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(flag_we),
    .wr_data(flag_wdata), .flags(flags)
  );

  assign flag_rd = {{PAD_W{1'b0}}, flags};
  assign irq     = |flags;
endmodule

// File: rtl/irq_watch_chk.sv
module irq_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       timer_pulse,
  input logic       flag_we,
  input logic [2:0] flag_wdata,
  input logic [7:0] flag_rd,
  input logic       irq,
  input logic       nmi
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd[7:3] == 5'd0); // R4
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flag_rd[2:0] != 3'd0)); // R4
  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_wdata[1] && !timer_pulse) |=> !flag_rd[1]); // R2
  AST_TMR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    timer_pulse |=> flag_rd[1]); // R3
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd[1] && !(flag_we && !flag_wdata[1])) |=> flag_rd[1]); // R9
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi); // R5
endmodule

bind irq_watch_ctrl irq_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .timer_pulse(timer_pulse), .flag_we(flag_we),
  .flag_wdata(flag_wdata), .flag_rd(flag_rd), .irq(irq), .nmi(nmi)
);

// File: tb/test_irq_watch_ctrl.sv
module test_irq_watch_ctrl;
  localparam int DIV_W = 6;
  localparam int NSH   = 2;
  localparam int PW    = 8;

  logic clk = 1'b0;
  logic rst_n, tick_32k, timer_pulse, rate_we, rate_wdata, flag_we;
  logic [PW-1:0] port_pins, wake_en;
  logic [2:0] flag_wdata;
  logic [7:0] flag_rd;
  logic irq, nmi;
  int errors = 0, checks = 0, gtick = 0;
  logic rate = 1'b0;

  always #4 clk = ~clk;

  irq_watch_ctrl #(.DIV_W(DIV_W), .NMI_SHIFT(NSH), .PORT_W(PW)) i_irq_watch_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .timer_pulse(timer_pulse),
    .port_pins(port_pins), .wake_en(wake_en), .rate_we(rate_we),
    .rate_wdata(rate_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .flag_rd(flag_rd), .irq(irq), .nmi(nmi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_flags(input logic [2:0] d);
    flag_we = 1'b1; flag_wdata = d; cyc(1); flag_we = 1'b0;
  endtask

  task automatic do_tick();
    bit exp_nmi, exp_w;
    tick_32k = 1'b1; cyc(1); tick_32k = 1'b0;
    exp_nmi = (gtick % (1 << NSH)) == ((1 << NSH) - 1);
    exp_w = rate ? (gtick % (1 << DIV_W)) == ((1 << DIV_W) - 1)
                 : (gtick % (1 << (DIV_W-1))) == ((1 << (DIV_W-1)) - 1);
    gtick++;
    chk(nmi == exp_nmi, "R5 nmi", nmi, exp_nmi);
    chk(flag_rd[0] == exp_w, "R6 watch flag", flag_rd[0], exp_w);
    if (exp_w) begin
      wr_flags(3'b110);
      chk(flag_rd[0] == 1'b0, "R2 clear watch", flag_rd[0], 0);
      chk(nmi == 1'b0, "R5 nmi width", nmi, 0);
    end
  endtask

  initial begin
    #(8*200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_32k = 0; timer_pulse = 0; rate_we = 0; rate_wdata = 0;
    flag_we = 0; flag_wdata = 3'b111; port_pins = '1; wake_en = '0;
    cyc(3); rst_n = 1'b1; cyc(2);
    chk(flag_rd == 8'h00, "R1 flags", flag_rd, 0);
    chk(irq == 1'b0 && nmi == 1'b0, "R1 irq nmi", {irq, nmi}, 0);

    // R6 half-second rate (also R1 default), then one-second rate
    for (int i = 0; i < 128; i++) do_tick();
    rate_we = 1'b1; rate_wdata = 1'b1; cyc(1); rate_we = 1'b0; rate = 1'b1;
    for (int i = 0; i < 256; i++) do_tick();

    // R7 timer pulse, R4 irq, R9 hold
    timer_pulse = 1'b1; cyc(1); timer_pulse = 1'b0;
    chk(flag_rd == 8'h02, "R7 timer set", flag_rd, 8'h02);
    chk(irq == 1'b1, "R4 irq high", irq, 1);
    cyc(5);
    chk(flag_rd == 8'h02, "R9 hold", flag_rd, 8'h02);
    wr_flags(3'b111);
    chk(flag_rd == 8'h02, "R2 write ones keeps", flag_rd, 8'h02);
    wr_flags(3'b101);
    chk(flag_rd == 8'h00 && irq == 1'b0, "R2 R4 clear", {irq, flag_rd}, 0);

    // R3 set beats simultaneous clear
    timer_pulse = 1'b1; flag_we = 1'b1; flag_wdata = 3'b000; cyc(1);
    timer_pulse = 1'b0; flag_we = 1'b0;
    chk(flag_rd == 8'h02, "R3 set wins", flag_rd, 8'h02);
    wr_flags(3'b000);

    // R8 sweep over every pin
    for (int p = 0; p < PW; p++) begin
      wake_en = PW'(1) << p;
      port_pins[(p+1)%PW] = 1'b0; cyc(4);
      chk(flag_rd == 8'h00, "R8 disabled pin", flag_rd, 0);
      port_pins[(p+1)%PW] = 1'b1; cyc(4);
      chk(flag_rd == 8'h00, "R8 rising ignored", flag_rd, 0);
      port_pins[p] = 1'b0; cyc(2);
      chk(flag_rd == 8'h00, "R8 sync latency", flag_rd, 0);
      cyc(1);
      chk(flag_rd == 8'h04 && irq, "R8 ext set", flag_rd, 8'h04);
      wr_flags(3'b011);
      chk(flag_rd == 8'h00, "R2 clear ext", flag_rd, 0);
      port_pins[p] = 1'b1; cyc(4);
      chk(flag_rd == 8'h00, "R8 release", flag_rd, 0);
    end

    // R2 read-invert-write clears only flags seen
    timer_pulse = 1'b1; cyc(1); timer_pulse = 1'b0;
    wake_en = 8'h01; port_pins[0] = 1'b0; cyc(3);
    chk(flag_rd == 8'h06, "R2 two flags", flag_rd, 8'h06);
    wr_flags(~flag_rd[2:0]);
    chk(flag_rd == 8'h00, "R2 invert write", flag_rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule